// File: doc/BRIEF.md
# Memory Controller Register Stub

This block provides the control and status registers that boot firmware expects from a DRAM controller, without any DRAM logic behind them. Firmware writes start commands and calibration requests, then polls. This block makes each of those polls succeed on the first read. Bits that a real controller clears when an operation completes are cleared as soon as they are written. Any write that starts impedance calibration immediately marks calibration as finished in a separate status register.

The block sits on a plain 32-bit register bus. The bus has a 4 KiB window with a word address, a write strobe with data, and a read strobe. Read data is combinational from the stored registers. The bus has no byte enables or size signal, so every access is a full 32-bit word. Three registers are implemented: a configuration register, a calibration control register and a calibration status register. Every other word in the window reads as zero and ignores writes.

Top module: `memctl_reg_stub`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the registers load their reset values: configuration 0x80020000, calibration control 0x07B00000 and calibration status 0x80000000.
- R2: The configuration register is at byte offset 0x000, calibration control at 0x0A8 and calibration status at 0x0B0. Address bits [1:0] are ignored when decoding.
- R3: A write to the configuration register stores `wr_data` with bit 31 (init start) and bit 30 (training start) forced to 0. All other bits are stored as written.
- R4: A write to the calibration control register stores `wr_data` and sets bit 31 (calibration done) of the status register. Status bits 30:0 keep their previous value.
- R5: A read of any word other than the three registers returns 0, including offsets 0x2E4 to 0xFFF. While `rd_en` is low, `rd_data` is 0.
- R6: A write to an unimplemented or out-of-range offset leaves all three registers unchanged. Reads never change any register.
- R7: A write to the calibration status register stores `wr_data` as given, so firmware can clear the done flag.
- R8: A write takes effect at the clock edge that samples it. A read in the same cycle returns the old value, and a read in the next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W (12) | Byte address within the window |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational |

## Verification
The assertions assume that `wr_en`, `rd_en` and `addr` are known and stable at each sampled edge. They also assume that each cycle carries at most one write. The bench keeps to this by changing inputs only on the falling edge and by sending one access per cycle. The only exception is the R8 case, where a read and a write to the same word share a cycle on purpose. The address decode is assumed to select at most one register, and this is checked separately. The hold checks compare against the register values from the previous cycle only, so they are valid from the first cycle after reset.

// File: rtl/memstub_pkg.sv
package memstub_pkg;

    localparam int REG_W = 32;
    localparam int NREG  = 3;

    // Register slots; order is used by the decoder and the read mux.
    localparam int IDX_CFG   = 0;
    localparam int IDX_ZQCTL = 1;
    localparam int IDX_ZQSTA = 2;

    localparam logic [31:0] REG_OFS [NREG] = '{32'h000, 32'h0A8, 32'h0B0};

    localparam logic [REG_W-1:0] CFG_RST   = 32'h8002_0000;
    localparam logic [REG_W-1:0] ZQCTL_RST = 32'h07B0_0000;
    localparam logic [REG_W-1:0] ZQSTA_RST = 32'h8000_0000;

    localparam logic [REG_W-1:0] CFG_AUTOCLR = 32'hC000_0000;
    localparam logic [REG_W-1:0] ZQ_DONE     = 32'h8000_0000;

    typedef struct packed {
        logic [REG_W-1:0] zqsta;
        logic [REG_W-1:0] zqctl;
        logic [REG_W-1:0] cfg;
    } regs_t;

endpackage

// File: rtl/stub_addr_dec.sv
module stub_addr_dec
    import memstub_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   sel
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word_idx;
    assign word_idx = addr[ADDR_W-1:2];

    for (genvar g = 0; g < NREG; g++) begin : g_match
        localparam logic [31:0] OFS = REG_OFS[g];
        assign sel[g] = (word_idx == OFS[ADDR_W-1:2]);
    end
endmodule

// File: rtl/stub_rd_mux.sv
module stub_rd_mux
    import memstub_pkg::*;
(
    input  logic                       rd_en,
    input  logic [NREG-1:0]            sel,
    input  logic [NREG-1:0][REG_W-1:0] reg_vec,
    output logic [REG_W-1:0]           rd_data
);
    logic [NREG-1:0][REG_W-1:0] gated;

    for (genvar g = 0; g < NREG; g++) begin : g_gate
        assign gated[g] = (rd_en && sel[g]) ? reg_vec[g] : '0;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            rd_data = rd_data | gated[i];
        end
    end
endmodule

// File: rtl/memctl_reg_stub.sv
module memctl_reg_stub
    import memstub_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data
);
    logic [NREG-1:0]            sel;
    logic [NREG-1:0][REG_W-1:0] reg_vec;
    regs_t                      regs_d, regs_q;

    stub_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (sel[IDX_CFG]) begin
                regs_d.cfg = wr_data & ~CFG_AUTOCLR;
            end
            if (sel[IDX_ZQCTL]) begin
                regs_d.zqctl = wr_data;
                regs_d.zqsta = regs_q.zqsta | ZQ_DONE;
            end
            if (sel[IDX_ZQSTA]) begin
                regs_d.zqsta = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.cfg   <= CFG_RST;
            regs_q.zqctl <= ZQCTL_RST;
            regs_q.zqsta <= ZQSTA_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        reg_vec[IDX_CFG]   = regs_q.cfg;
        reg_vec[IDX_ZQCTL] = regs_q.zqctl;
        reg_vec[IDX_ZQSTA] = regs_q.zqsta;
    end

    stub_rd_mux u_mux (
        .rd_en   (rd_en),
        .sel     (sel),
        .reg_vec (reg_vec),
        .rd_data (rd_data)
    );

    // R2: decode never selects two registers
    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    p_autoclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel[IDX_CFG]) |=> (regs_q.cfg[31:30] == 2'b00));

    p_done_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel[IDX_ZQCTL]) |=> regs_q.zqsta[31]);

    p_sta_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel[IDX_ZQCTL]) |=> $stable(regs_q.zqsta[30:0]));

    p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0 || !rd_en) |-> (rd_data == '0));

    p_no_side_effect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || sel == '0) |=> $stable(regs_q));

    p_sta_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel[IDX_ZQSTA]) |=> (regs_q.zqsta == $past(wr_data)));
endmodule

// File: tb/sim_memctl_reg_stub.sv
module sim_memctl_reg_stub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    memctl_reg_stub #(.ADDR_W(12)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
    );

    // {is_read, req, addr, wdata, expected}
    localparam int NV = 26;
    localparam logic [84:0] VEC [NV] = '{
        {1'b1, 8'd1, 12'h000, 32'h0,         32'h8002_0000}, // R1
        {1'b1, 8'd1, 12'h0A8, 32'h0,         32'h07B0_0000}, // R1
        {1'b1, 8'd1, 12'h0B0, 32'h0,         32'h8000_0000}, // R1
        {1'b0, 8'd7, 12'h0B0, 32'h0,         32'h0},         // R7
        {1'b1, 8'd7, 12'h0B0, 32'h0,         32'h0},         // R7
        {1'b0, 8'd3, 12'h000, 32'hFFFF_FFFF, 32'h0},         // R3
        {1'b1, 8'd3, 12'h000, 32'h0,         32'h3FFF_FFFF}, // R3
        {1'b0, 8'd3, 12'h000, 32'hC000_1234, 32'h0},         // R3
        {1'b1, 8'd3, 12'h000, 32'h0,         32'h0000_1234}, // R3
        {1'b0, 8'd4, 12'h0A8, 32'h1234_5678, 32'h0},         // R4
        {1'b1, 8'd4, 12'h0A8, 32'h0,         32'h1234_5678}, // R4
        {1'b1, 8'd4, 12'h0B0, 32'h0,         32'h8000_0000}, // R4
        {1'b0, 8'd7, 12'h0B0, 32'h0000_5A5A, 32'h0},         // R7
        {1'b0, 8'd4, 12'h0A8, 32'h0,         32'h0},         // R4
        {1'b1, 8'd4, 12'h0B0, 32'h0,         32'h8000_5A5A}, // R4
        {1'b0, 8'd6, 12'h004, 32'hDEAD_BEEF, 32'h0},         // R6
        {1'b1, 8'd5, 12'h004, 32'h0,         32'h0},         // R5
        {1'b1, 8'd6, 12'h000, 32'h0,         32'h0000_1234}, // R6
        {1'b0, 8'd6, 12'h2E4, 32'hFFFF_FFFF, 32'h0},         // R6
        {1'b1, 8'd5, 12'h2E4, 32'h0,         32'h0},         // R5
        {1'b0, 8'd6, 12'hFFC, 32'hFFFF_FFFF, 32'h0},         // R6
        {1'b1, 8'd5, 12'hFFC, 32'h0,         32'h0},         // R5
        {1'b1, 8'd6, 12'h0A8, 32'h0,         32'h0},         // R6
        {1'b0, 8'd2, 12'h0AB, 32'hAAAA_5555, 32'h0},         // R2
        {1'b1, 8'd2, 12'h0A9, 32'h0,         32'hAAAA_5555}, // R2
        {1'b1, 8'd2, 12'h0B2, 32'h0,         32'h8000_5A5A}  // R2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            addr    = VEC[i][75:64];
            wr_data = VEC[i][63:32];
            wr_en   = !VEC[i][84];
            rd_en   = VEC[i][84];
            #5;
            if (VEC[i][84]) begin
                check($sformatf("R%0d vec%0d", VEC[i][83:76], i), rd_data, VEC[i][31:0]);
            end
        end
        @(negedge clk); idle();

        // R5: no read strobe gives zero even on a mapped register
        @(negedge clk); addr = 12'h000; rd_en = 1'b0; #5;
        check("R5 rd_en low", rd_data, 32'h0);

        // R8: read and write in the same cycle returns the old value
        @(negedge clk);
        addr = 12'h000; wr_en = 1'b1; wr_data = 32'h0000_00AB; rd_en = 1'b1; #5;
        check("R8 same-cycle old", rd_data, 32'h0000_1234);
        @(negedge clk); wr_en = 1'b0; #5;
        check("R8 next-cycle new", rd_data, 32'h0000_00AB);

        // R1: reset mid-run restores all three registers
        @(negedge clk); idle(); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_en = 1'b1; addr = 12'h000; #5;
        check("R1 cfg after reset", rd_data, 32'h8002_0000);
        @(negedge clk); addr = 12'h0A8; #5;
        check("R1 zqctl after reset", rd_data, 32'h07B0_0000);
        @(negedge clk); addr = 12'h0B0; #5;
        check("R1 zqsta after reset", rd_data, 32'h8000_0000);

        @(negedge clk); idle();
        finish_run();
    end
endmodule